// File: doc/BRIEF.md
# Smartcard ETU Timing Controller

This block holds the character-level timing of a smartcard serial port. It counts elementary time units (ETUs) from a single-cycle tick provided by the bit-level logic. It runs two independent down-counters. The guard counter starts when a character ends. The waiting counter restarts whenever a new character begins. The block also collects four sticky status flags and merges them into one interrupt line.

Two protocol modes are supported. In the byte-oriented mode (T=0) every character uses the programmed guard count. In the block-oriented mode (T=1) a character tagged as the final one of a block replaces the guard count with a fixed 22-ETU interval. When that interval ends, the interrupt line is driven whatever the enable settings are. Counts are exact: a programmed value of N gives N ETUs, with no extra unit and no hidden extension.

Each flag is cleared by its own strobe and leaves the others alone. A receive-complete pulse is issued only once the guard portion of a received character has run out.

Top module: `smc_etu_ctrl`

## Requirements
- R1: After reset, `flags`, `irq` and `rx_done` are all 0.
- R2: With `char_end` sampled high and a guard value N (9-bit field), flag bit 0 (guard) rises right after the clock edge that samples the N-th `etu_tick` following it, and not earlier. N=0 sets the flag one clock after `char_end`.
- R3: With `mode_t1`=1 and `char_last`=1 at `char_end`, flag bit 0 rises exactly at the 22nd ETU tick, and `irq` asserts then even when every bit of `irq_en` is 0. Clearing flag bit 0 also removes this forced request.
- R4: With `mode_t1`=0, `char_last` has no effect: the guard interval is the programmed value and no forced interrupt occurs.
- R5: After `char_start`, flag bit 1 (waiting) rises right after the edge sampling the W-th ETU tick, where W is `wait_val`, for every W including values above 10. W=0 sets it one clock after `char_start`. A new `char_start` restarts the count from zero.
- R6: A `tx_repeat` pulse sets flag bit 2 and an `rx_repeat` pulse sets flag bit 3, one clock later.
- R7: A pulse on `flag_clr[i]` clears flag bit i only. The other three flags are unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R8: `irq` equals the OR over i of `flags[i]` AND `irq_en[i]`, apart from the forced request of R3.
- R9: `rx_done` pulses high for one clock, at the same edge the guard flag rises, only if the character that started the guard interval had `char_is_rx`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| mode_t1 | input | 1 | 1 selects block protocol T=1, 0 selects T=0 |
| guard_val | input | GT_W | Guard interval in ETUs |
| wait_val | input | WT_W | Waiting interval in ETUs |
| irq_en | input | 4 | Per-flag interrupt enables |
| char_start | input | 1 | Strobe: a character start edge was seen |
| char_end | input | 1 | Strobe: a character finished its stop bit |
| char_is_rx | input | 1 | Qualifies `char_end`: the character was received |
| char_last | input | 1 | Qualifies `char_end`: last character of a T=1 block |
| tx_repeat | input | 1 | Strobe: transmit character repeat requested |
| rx_repeat | input | 1 | Strobe: receive character repeat requested |
| flag_clr | input | 4 | Per-flag clear strobes |
| flags | output | 4 | Status: bit0 guard, bit1 waiting, bit2 tx repeat, bit3 rx repeat |
| irq | output | 1 | Interrupt request |
| rx_done | output | 1 | Receive-complete pulse |

## Verification
The bench keeps the 9-bit guard field and narrows the waiting counter to `WT_W`=10. With that width the largest waiting count, 1023 ETUs, fits within a short run next to the guard maximum of 511. Guard and waiting values from 0 to 24 are swept tick by tick, which covers the 10/11 boundary and the single-ETU and zero cases, and both maxima are run as well. All 16 flag patterns are then crossed with all 16 enable masks.

// File: rtl/smc_etu_pkg.sv
package smc_etu_pkg;
    localparam int FLAG_N = 4;

    // Flag positions inside the status vector
    typedef enum int unsigned {
        F_GUARD = 0,
        F_WAIT  = 1,
        F_TXREP = 2,
        F_RXREP = 3
    } flag_idx_e;
endpackage

// File: rtl/smc_etu_timer.sv
// Loadable ETU down-counter: expire is high in the cycle before the edge
// that consumes the final tick (or right after load when the count is 0).
module smc_etu_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        expire = st_q.run && ((st_q.cnt == '0) || (tick && st_q.cnt == CW'(1)));
        st_d   = st_q;
        if (load) begin
            st_d.cnt = load_val;
            st_d.run = 1'b1;
        end else if (expire) begin
            st_d.run = 1'b0;
        end else if (tick && st_q.run) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2/R5: one expiry per load, then idle
    p_idle_after_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> !st_q.run);

    // R2/R5: every tick between load and expiry removes exactly one unit
    p_one_per_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick && !load && !expire) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));
endmodule

// File: rtl/smc_flag_bank.sv
// Sticky status flags with independent set/clear and interrupt merge.
module smc_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ien,
    input  logic         force_set,
    input  logic         force_clr,
    output logic [N-1:0] flags,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] flg;
        logic         frc;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d.flg = (st_q.flg & ~clr) | set;
        st_d.frc = (st_q.frc & ~force_clr) | force_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;
    assign irq   = (|(st_q.flg & ien)) | st_q.frc;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7: a lone clear drops only its own bit
        p_clear_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags[i]);
        // R7: untouched bits keep their value
        p_hold_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !set[i]) |=> (flags[i] == $past(flags[i])));
        // R6: a set always lands, even against a clear
        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end

    // R8: an enabled flag always reaches the interrupt line
    p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ien)) |-> irq);
endmodule

// File: rtl/smc_etu_ctrl.sv
module smc_etu_ctrl
    import smc_etu_pkg::*;
#(
    parameter int GT_W     = 9,
    parameter int WT_W     = 16,
    parameter int LAST_ETU = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            etu_tick,
    input  logic            mode_t1,
    input  logic [GT_W-1:0] guard_val,
    input  logic [WT_W-1:0] wait_val,
    input  logic [3:0]      irq_en,
    input  logic            char_start,
    input  logic            char_end,
    input  logic            char_is_rx,
    input  logic            char_last,
    input  logic            tx_repeat,
    input  logic            rx_repeat,
    input  logic [3:0]      flag_clr,
    output logic [3:0]      flags,
    output logic            irq,
    output logic            rx_done
);
    localparam int LW = $clog2(LAST_ETU + 1);
    localparam int CW = (GT_W > LW) ? GT_W : LW;

    typedef struct packed {
        logic last;
        logic rx;
        logic done;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          gt_exp, wt_exp;
    logic [CW-1:0] gt_load;
    logic [FLAG_N-1:0] set_vec;

    always_comb begin
        gt_load = (mode_t1 && char_last) ? CW'(LAST_ETU) : CW'(guard_val);

        ctl_d      = ctl_q;
        ctl_d.done = gt_exp && ctl_q.rx;
        if (char_end) begin
            ctl_d.last = mode_t1 && char_last;
            ctl_d.rx   = char_is_rx;
        end

        set_vec          = '0;
        set_vec[F_GUARD] = gt_exp;
        set_vec[F_WAIT]  = wt_exp;
        set_vec[F_TXREP] = tx_repeat;
        set_vec[F_RXREP] = rx_repeat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    smc_etu_timer #(.CW(CW)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (etu_tick),
        .load     (char_end),
        .load_val (gt_load),
        .expire   (gt_exp)
    );

    smc_etu_timer #(.CW(WT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (etu_tick),
        .load     (char_start),
        .load_val (wait_val),
        .expire   (wt_exp)
    );

    smc_flag_bank #(.N(FLAG_N)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (set_vec),
        .clr       (flag_clr),
        .ien       (irq_en),
        .force_set (gt_exp && ctl_q.last),
        .force_clr (flag_clr[F_GUARD]),
        .flags     (flags),
        .irq       (irq)
    );

    assign rx_done = ctl_q.done;

    // R3: end of a T=1 block interval requests an interrupt unconditionally
    p_block_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gt_exp && ctl_q.last && !char_end) |=> irq);

    // R9: receive completion coincides with the guard flag
    p_rxdone_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> flags[F_GUARD]);

    // R9: the completion indication is a single-cycle pulse
    p_rxdone_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
endmodule

// File: tb/smc_etu_ctrl_bench.sv
module smc_etu_ctrl_bench;
    localparam int GT_W = 9;
    localparam int WT_W = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            etu_tick = 1'b0;
    logic            mode_t1 = 1'b0;
    logic [GT_W-1:0] guard_val = '0;
    logic [WT_W-1:0] wait_val = '0;
    logic [3:0]      irq_en = '0;
    logic            char_start = 1'b0;
    logic            char_end = 1'b0;
    logic            char_is_rx = 1'b0;
    logic            char_last = 1'b0;
    logic            tx_repeat = 1'b0;
    logic            rx_repeat = 1'b0;
    logic [3:0]      flag_clr = '0;
    logic [3:0]      flags;
    logic            irq;
    logic            rx_done;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    smc_etu_ctrl #(.GT_W(GT_W), .WT_W(WT_W), .LAST_ETU(22)) u_smc_etu_ctrl (
        .clk, .rst_n, .etu_tick, .mode_t1, .guard_val, .wait_val, .irq_en,
        .char_start, .char_end, .char_is_rx, .char_last, .tx_repeat, .rx_repeat,
        .flag_clr, .flags, .irq, .rx_done
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        flag_clr = 4'hF;
        step();
        flag_clr = 4'h0;
    endtask

    task automatic tick_once();
        etu_tick = 1'b1;
        step();
        etu_tick = 1'b0;
    endtask

    // Guard interval check: count ETUs after char_end
    task automatic run_guard(input int n, input bit t1, input bit last, input int exp_n,
                             input bit rx, input string req);
        clear_all();
        mode_t1 = t1; char_last = last; char_is_rx = rx;
        guard_val = GT_W'(n);
        char_end = 1'b1;
        step();
        char_end = 1'b0; char_last = 1'b0; char_is_rx = 1'b0;
        if (exp_n == 0) begin
            chk(req, int'(flags[0]), 0);
            step();
            chk(req, int'(flags[0]), 1);
            chk("R9", int'(rx_done), int'(rx));
        end else begin
            for (int k = 1; k <= exp_n; k++) begin
                tick_once();
                chk(req, int'(flags[0]), (k == exp_n) ? 1 : 0);
                if (k == exp_n) chk("R9", int'(rx_done), int'(rx));
                else if (k % 8 == 0) begin
                    step();
                    chk(req, int'(flags[0]), 0);
                end
            end
        end
        step();
        chk("R9", int'(rx_done), 0);
    endtask

    task automatic run_wait(input int w);
        clear_all();
        wait_val = WT_W'(w);
        char_start = 1'b1;
        step();
        char_start = 1'b0;
        if (w == 0) begin
            chk("R5", int'(flags[1]), 0);
            step();
            chk("R5", int'(flags[1]), 1);
        end else begin
            for (int k = 1; k <= w; k++) begin
                tick_once();
                chk("R5", int'(flags[1]), (k == w) ? 1 : 0);
            end
        end
    endtask

    // Set all four flags, then clear those not in pattern p
    task automatic make_flags(input logic [3:0] p);
        guard_val = '0; wait_val = '0; mode_t1 = 1'b0;
        char_end = 1'b1; char_start = 1'b1; tx_repeat = 1'b1; rx_repeat = 1'b1;
        step();
        char_end = 1'b0; char_start = 1'b0; tx_repeat = 1'b0; rx_repeat = 1'b0;
        step();
        flag_clr = ~p;
        step();
        flag_clr = 4'h0;
    endtask

    initial begin
        step(); step(); step();
        chk("R1", int'(flags), 0);
        chk("R1", int'(irq), 0);
        chk("R1", int'(rx_done), 0);
        rst_n = 1'b1;
        step();

        // R2: guard sweep and maximum
        for (int n = 0; n <= 24; n++) run_guard(n, 1'b0, 1'b0, n, 1'b0, "R2");
        run_guard(511, 1'b0, 1'b0, 511, 1'b0, "R2");
        run_guard(0, 1'b1, 1'b0, 0, 1'b0, "R2");
        run_guard(11, 1'b1, 1'b0, 11, 1'b0, "R2");

        // R3: last byte of a T=1 block, all enables off
        irq_en = 4'h0;
        run_guard(3, 1'b1, 1'b1, 22, 1'b0, "R3");
        chk("R3", int'(irq), 1);
        flag_clr = 4'b0001;
        step();
        flag_clr = 4'h0;
        chk("R3", int'(irq), 0);
        chk("R3", int'(flags[0]), 0);

        // R4: last marker ignored in T=0
        run_guard(3, 1'b0, 1'b1, 3, 1'b0, "R4");
        chk("R4", int'(irq), 0);

        // R9: receive completion only for received characters
        run_guard(2, 1'b0, 1'b0, 2, 1'b1, "R9");
        run_guard(0, 1'b0, 1'b0, 0, 1'b1, "R9");
        run_guard(4, 1'b0, 1'b0, 4, 1'b0, "R9");

        // R5: waiting sweep, maximum and restart
        for (int w = 0; w <= 24; w++) run_wait(w);
        run_wait(1023);
        clear_all();
        wait_val = WT_W'(8);
        char_start = 1'b1; step(); char_start = 1'b0;
        for (int k = 0; k < 5; k++) tick_once();
        char_start = 1'b1; step(); char_start = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            tick_once();
            chk("R5", int'(flags[1]), (k == 8) ? 1 : 0);
        end

        // R6: repeat strobes
        clear_all();
        tx_repeat = 1'b1; step(); tx_repeat = 1'b0;
        chk("R6", int'(flags), 4'b0100);
        rx_repeat = 1'b1; step(); rx_repeat = 1'b0;
        chk("R6", int'(flags), 4'b1100);

        // R7: single-bit clears, and set beating clear
        for (int i = 0; i < 4; i++) begin
            make_flags(4'hF);
            chk("R7", int'(flags), 15);
            flag_clr = 4'(1 << i);
            step();
            flag_clr = 4'h0;
            chk("R7", int'(flags), 15 & ~(1 << i));
        end
        clear_all();
        tx_repeat = 1'b1; flag_clr = 4'b0100;
        step();
        tx_repeat = 1'b0; flag_clr = 4'h0;
        chk("R7", int'(flags[2]), 1);

        // R8: every flag pattern against every enable mask
        for (int p = 0; p < 16; p++) begin
            make_flags(4'(p));
            chk("R8", int'(flags), p);
            for (int e = 0; e < 16; e++) begin
                irq_en = 4'(e);
                #1;
                chk("R8", int'(irq), ((p & e) != 0) ? 1 : 0);
            end
            irq_en = 4'h0;
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule